// File: doc/BRIEF.md
# Security-Aware Interrupt Priority Arbiter

This block keeps a programmable priority byte and a security-target flag for each of a parameterized set of interrupt sources. From the pending lines it picks the most urgent source. It then compares that source's group priority with the priority of the code that is running now. The result says whether the source may preempt, or whether it has to wait and be tail-chained after the current handler.

Only the upper `PRIO_BITS` bits of each priority byte are kept. A boost control bit, which only secure accesses can change, pushes every non-secure source into the lower-urgency half of the scale while the arbiter evaluates it. Software that reads a priority back always sees the value it wrote, never the remapped one. A split register divides the effective priority into group bits and subpriority bits. Only the group bits decide preemption.

Top module: `irq_prio_arb`

## Requirements
- R1: Only the top `PRIO_BITS` bits (2 to 8) of a written priority are stored. The low bits always read back as 0 and are evaluated as 0.
- R2: With boost off, a source flagged non-secure gets the same effective priority as a secure one. With 2 bits the levels are 0, 64, 128 and 192.
- R3: With boost on, a non-secure source's effective priority is its stored value shifted right by one, with bit 7 forced to 1. With 2 bits this gives 128, 160, 192 or 224.
- R4: With more than 2 bits and boost on, the lowest implemented bit of the shifted value is cleared. With 5 bits, 240 and 248 both evaluate as 248.
- R5: `preempt` is 1 only when the selected source's effective group priority is numerically below `cur_prio`. Otherwise a valid selection raises `tail_chain`, and this includes equal values.
- R6: The split register (`wr_sel`/`rd_sel` = 3, 3-bit value s) makes the low s bits of the effective priority subpriority. Those bits are masked out before the comparison with `cur_prio`.
- R7: A priority read (`rd_sel` = 0) returns the stored value, whatever the boost and target state.
- R8: The boost bit (`wr_sel` = 2, `wr_data[0]`) and the target flags (`wr_sel` = 1, `wr_data[0]`, 1 = non-secure) change only on writes with `wr_secure` = 1. A non-secure read of the boost bit returns 0.
- R9: Among pending sources, the one with the lowest effective priority is selected. Ties go to the lowest index.
- R10: Outputs are registered and reflect inputs and register state one clock earlier. With nothing pending, `sel_valid`, `sel_id`, `preempt` and `tail_chain` are all 0.
- R11: Synchronous active-low reset clears all priorities, target flags (all secure), boost, split and outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pend | input | NUM_SRC | Pending line per source |
| cur_prio | input | 8 | Priority of the running context |
| wr_en | input | 1 | Register write strobe |
| wr_secure | input | 1 | Write issued by secure software |
| wr_sel | input | 2 | Write target: 0 priority, 1 target flag, 2 boost, 3 split |
| wr_idx | input | ID_W | Source index for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_idx | input | ID_W | Source index for reads |
| rd_secure | input | 1 | Read issued by secure software |
| rd_data | output | 8 | Combinational readback |
| sel_valid | output | 1 | A source is selected |
| sel_id | output | ID_W | Selected source index |
| preempt | output | 1 | Selected source may preempt |
| tail_chain | output | 1 | Selected source must wait |

## Verification
Two instances run side by side, one with 5 implemented bits and one with 2. The same stimulus therefore separates the truncating variant from the extra-bit variant. A 240/248 pair against a running level of 248 tells boost-on apart from boost-off. Equal and off-by-one `cur_prio` values separate strict from non-strict preemption. Pairs of sources with equal priorities test the lowest-index tie rule, and a secure/non-secure pair shows the boost flipping the winner. Non-secure writes and reads of protected bits check that they leave no trace. Split settings show when subpriority bits stop counting. A long random phase is compared against the reference model on every cycle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   typedef logic [7:0] prio_t;

   typedef enum logic [1:0] {
      REG_PRIO  = 2'd0,
      REG_TGT   = 2'd1,
      REG_BOOST = 2'd2,
      REG_SPLIT = 2'd3
   } reg_sel_e;

   function automatic prio_t impl_mask(input int bits);
      prio_t m;
      m = 8'hFF;
      m = m << (8 - bits);
      return m;
   endfunction
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
   import irq_prio_pkg::*;
#(
   parameter int NUM_SRC   = 8,
   parameter int PRIO_BITS = 3,
   parameter int ID_W      = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     wr_secure,
   input  logic [1:0]               wr_sel,
   input  logic [ID_W-1:0]          wr_idx,
   input  logic [7:0]               wr_data,
   input  logic [1:0]               rd_sel,
   input  logic [ID_W-1:0]          rd_idx,
   input  logic                     rd_secure,
   output logic [7:0]               rd_data,
   output logic [NUM_SRC-1:0][7:0]  prio_o,
   output logic [NUM_SRC-1:0]       tgt_o,
   output logic                     boost_o,
   output logic [2:0]               split_o
);
   localparam prio_t IMASK = impl_mask(PRIO_BITS);

   logic [NUM_SRC-1:0][7:0] prio_q;
   logic [NUM_SRC-1:0]      tgt_q;
   logic                    boost_q;
   logic [2:0]              split_q;
   logic                    wr_idx_ok, rd_idx_ok;

   assign wr_idx_ok = int'(wr_idx) < NUM_SRC;
   assign rd_idx_ok = int'(rd_idx) < NUM_SRC;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prio_q  <= '0;
         tgt_q   <= '0;
         boost_q <= 1'b0;
         split_q <= '0;
      end else if (wr_en) begin
         case (reg_sel_e'(wr_sel))
            REG_PRIO:  if (wr_idx_ok) prio_q[wr_idx] <= wr_data & IMASK;
            REG_TGT:   if (wr_idx_ok && wr_secure) tgt_q[wr_idx] <= wr_data[0];
            REG_BOOST: if (wr_secure) boost_q <= wr_data[0];
            REG_SPLIT: split_q <= wr_data[2:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (reg_sel_e'(rd_sel))
         REG_PRIO:  if (rd_idx_ok) rd_data = prio_q[rd_idx];
         REG_TGT:   if (rd_idx_ok) rd_data = {7'b0, tgt_q[rd_idx]};
         REG_BOOST: rd_data = {7'b0, boost_q & rd_secure};
         REG_SPLIT: rd_data = {5'b0, split_q};
         default: ;
      endcase
   end

   assign prio_o  = prio_q;
   assign tgt_o   = tgt_q;
   assign boost_o = boost_q;
   assign split_o = split_q;
endmodule

// File: rtl/irq_prio_eff.sv
module irq_prio_eff
   import irq_prio_pkg::*;
#(
   parameter int NUM_SRC   = 8,
   parameter int PRIO_BITS = 3
) (
   input  logic [NUM_SRC-1:0][7:0] prio_i,
   input  logic [NUM_SRC-1:0]      tgt_i,
   input  logic                    boost_i,
   output logic [NUM_SRC-1:0][7:0] eff_o
);
   localparam prio_t IMASK = impl_mask(PRIO_BITS);

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      prio_t shifted;
      prio_t boosted;
      assign shifted = {1'b1, prio_i[g][7:1]};
      if (PRIO_BITS == 2) begin : g_extra_bit
         assign boosted = shifted;
      end else begin : g_truncate
         assign boosted = shifted & IMASK;
      end
      assign eff_o[g] = (tgt_i[g] && boost_i) ? boosted : prio_i[g];
   end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
   parameter int NUM_SRC = 8,
   parameter int ID_W    = 3
) (
   input  logic [NUM_SRC-1:0]      pend_i,
   input  logic [NUM_SRC-1:0][7:0] eff_i,
   output logic                    found_o,
   output logic [ID_W-1:0]         id_o,
   output logic [7:0]              best_o
);
   always_comb begin
      found_o = 1'b0;
      id_o    = '0;
      best_o  = 8'hFF;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (pend_i[i] && (!found_o || eff_i[i] < best_o)) begin
            found_o = 1'b1;
            id_o    = ID_W'(i);
            best_o  = eff_i[i];
         end
      end
   end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
   import irq_prio_pkg::*;
#(
   parameter int NUM_SRC   = 8,
   parameter int PRIO_BITS = 3,
   localparam int ID_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend,
   input  logic [7:0]         cur_prio,
   input  logic               wr_en,
   input  logic               wr_secure,
   input  logic [1:0]         wr_sel,
   input  logic [ID_W-1:0]    wr_idx,
   input  logic [7:0]         wr_data,
   input  logic [1:0]         rd_sel,
   input  logic [ID_W-1:0]    rd_idx,
   input  logic               rd_secure,
   output logic [7:0]         rd_data,
   output logic               sel_valid,
   output logic [ID_W-1:0]    sel_id,
   output logic               preempt,
   output logic               tail_chain
);
   if (PRIO_BITS < 2 || PRIO_BITS > 8) begin : g_bad_bits
      $error("irq_prio_arb: PRIO_BITS must lie in 2..8");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("irq_prio_arb: NUM_SRC must be at least 1");
   end

   logic [NUM_SRC-1:0][7:0] prio_w, eff_w;
   logic [NUM_SRC-1:0]      tgt_w;
   logic                    boost_q;
   logic [2:0]              split_w;
   logic                    found_w;
   logic [ID_W-1:0]         id_w;
   prio_t                   best_w, grp_mask, grp_w;
   logic                    wins_w;

   irq_prio_regs #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_secure(wr_secure),
      .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_secure(rd_secure), .rd_data(rd_data),
      .prio_o(prio_w), .tgt_o(tgt_w), .boost_o(boost_q), .split_o(split_w)
   );

   irq_prio_eff #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS)) u_eff (
      .prio_i(prio_w), .tgt_i(tgt_w), .boost_i(boost_q), .eff_o(eff_w)
   );

   irq_prio_select #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_sel (
      .pend_i(pend), .eff_i(eff_w), .found_o(found_w), .id_o(id_w), .best_o(best_w)
   );

   always_comb begin
      grp_mask = 8'hFF << split_w;
      grp_w    = best_w & grp_mask;
      wins_w   = found_w && (grp_w < cur_prio);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_valid  <= 1'b0;
         sel_id     <= '0;
         preempt    <= 1'b0;
         tail_chain <= 1'b0;
      end else begin
         sel_valid  <= found_w;
         sel_id     <= found_w ? id_w : '0;
         preempt    <= wins_w;
         tail_chain <= found_w && !wins_w;
      end
   end
endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk
   import irq_prio_pkg::*;
#(
   parameter int NUM_SRC   = 8,
   parameter int PRIO_BITS = 3,
   parameter int ID_W      = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] pend,
   input logic               wr_en,
   input logic               wr_secure,
   input logic [1:0]         wr_sel,
   input logic [1:0]         rd_sel,
   input logic               rd_secure,
   input logic [7:0]         rd_data,
   input logic               sel_valid,
   input logic [ID_W-1:0]    sel_id,
   input logic               preempt,
   input logic               tail_chain,
   input logic               boost_q
);
   localparam prio_t IMASK = impl_mask(PRIO_BITS);
   logic [NUM_SRC-1:0] pend_d;
   always_ff @(posedge clk) pend_d <= pend;

   // R10
   no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |=> !sel_valid);
   // R9
   sel_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> pend_d[sel_id]);
   // R5
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (preempt || tail_chain) |-> (sel_valid && !(preempt && tail_chain)));
   // R8
   ns_boost_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_secure && wr_sel == 2'd2) |=> $stable(boost_q));
   // R8
   ns_boost_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == 2'd2 && !rd_secure) |-> (rd_data == 8'd0));
   // R1
   low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == 2'd0) |-> ((rd_data & ~IMASK) == 8'd0));
   // R11
   reset_out_chk: assert property (@(posedge clk)
      !rst_n |=> (!sel_valid && !preempt && !tail_chain));
endmodule

bind irq_prio_arb irq_prio_arb_chk #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pend(pend), .wr_en(wr_en), .wr_secure(wr_secure),
   .wr_sel(wr_sel), .rd_sel(rd_sel), .rd_secure(rd_secure), .rd_data(rd_data),
   .sel_valid(sel_valid), .sel_id(sel_id), .preempt(preempt),
   .tail_chain(tail_chain), .boost_q(boost_q)
);

// File: tb/tb_irq_prio_arb.sv
module tb_irq_prio_arb;
   localparam int N = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [N-1:0] pend = '0;
   logic [7:0] cur_prio = 8'hFF;
   logic       wr_en = 1'b0, wr_secure = 1'b0;
   logic [1:0] wr_sel = '0, rd_sel = '0;
   logic [2:0] wr_idx = '0, rd_idx = '0;
   logic [7:0] wr_data = '0;
   logic       rd_secure = 1'b0;

   logic [7:0] a_rd, b_rd;
   logic       a_v, b_v, a_pre, b_pre, a_tc, b_tc;
   logic [2:0] a_id, b_id;

   int checks = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   irq_prio_arb #(.NUM_SRC(N), .PRIO_BITS(5)) dut (
      .clk(clk), .rst_n(rst_n), .pend(pend), .cur_prio(cur_prio),
      .wr_en(wr_en), .wr_secure(wr_secure), .wr_sel(wr_sel), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_secure(rd_secure),
      .rd_data(a_rd), .sel_valid(a_v), .sel_id(a_id), .preempt(a_pre), .tail_chain(a_tc));

   irq_prio_arb #(.NUM_SRC(N), .PRIO_BITS(2)) dut_b2 (
      .clk(clk), .rst_n(rst_n), .pend(pend), .cur_prio(cur_prio),
      .wr_en(wr_en), .wr_secure(wr_secure), .wr_sel(wr_sel), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_secure(rd_secure),
      .rd_data(b_rd), .sel_valid(b_v), .sel_id(b_id), .preempt(b_pre), .tail_chain(b_tc));

   // ---------------- reference model ----------------
   logic [7:0] m_prio [N];
   logic       m_tgt  [N];
   logic       m_boost;
   logic [2:0] m_split;
   logic       ea_v, eb_v, ea_pre, eb_pre, ea_tc, eb_tc;
   int         ea_id, eb_id;

   function automatic logic [7:0] f_mask(int b);
      logic [7:0] m = 8'hFF;
      return m << (8 - b);
   endfunction

   function automatic logic [7:0] f_eff(logic [7:0] p, logic ns, logic bst, int b);
      logic [7:0] m = p & f_mask(b);
      logic [7:0] e;
      if (ns && bst) begin
         e = {1'b1, m[7:1]};
         if (b > 2) e = e & f_mask(b);
      end else e = m;
      return e;
   endfunction

   task automatic eval(input int b, output logic v, output int id, output logic pr, output logic tc);
      int best = -1;
      logic [7:0] be = 8'hFF, e, gm;
      for (int i = 0; i < N; i++) begin
         if (pend[i]) begin
            e = f_eff(m_prio[i], m_tgt[i], m_boost, b);
            if (best < 0 || e < be) begin best = i; be = e; end
         end
      end
      gm = 8'hFF << m_split;
      v  = best >= 0;
      id = v ? best : 0;
      pr = v && ((be & gm) < cur_prio);
      tc = v && !pr;
   endtask

   function automatic logic [7:0] rd_exp(int b);
      case (rd_sel)
         2'd0: return m_prio[rd_idx] & f_mask(b);
         2'd1: return {7'b0, m_tgt[rd_idx]};
         2'd2: return {7'b0, m_boost & rd_secure};
         default: return {5'b0, m_split};
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin m_prio[i] = '0; m_tgt[i] = 1'b0; end
         m_boost = 1'b0; m_split = '0;
         ea_v = 0; eb_v = 0; ea_pre = 0; eb_pre = 0; ea_tc = 0; eb_tc = 0; ea_id = 0; eb_id = 0;
      end else begin
         eval(5, ea_v, ea_id, ea_pre, ea_tc);
         eval(2, eb_v, eb_id, eb_pre, eb_tc);
         if (wr_en) begin
            case (wr_sel)
               2'd0: m_prio[wr_idx] = wr_data;
               2'd1: if (wr_secure) m_tgt[wr_idx] = wr_data[0];
               2'd2: if (wr_secure) m_boost = wr_data[0];
               default: m_split = wr_data[2:0];
            endcase
         end
      end
   end

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!done && m_prio[0] !== 8'bx) begin
         if (!rst_n) begin
            check("R11 reset a_v", a_v, 0);   check("R11 reset b_v", b_v, 0);
            check("R11 reset a_pre", a_pre, 0); check("R11 reset a_tc", a_tc, 0);
         end else begin
            check("R10 a sel_valid", a_v, ea_v);   check("R10 b sel_valid", b_v, eb_v);
            check("R9 a sel_id", a_id, ea_id);     check("R9 b sel_id", b_id, eb_id);
            check("R5 a preempt", a_pre, ea_pre);  check("R5 b preempt", b_pre, eb_pre);
            check("R5 a tail_chain", a_tc, ea_tc); check("R5 b tail_chain", b_tc, eb_tc);
            check("R7 a rd_data", a_rd, rd_exp(5)); check("R7 b rd_data", b_rd, rd_exp(2));
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr(logic [1:0] s, int idx, logic [7:0] d, logic sec);
      @(posedge clk); #2;
      wr_en = 1; wr_sel = s; wr_idx = idx[2:0]; wr_data = d; wr_secure = sec;
      @(posedge clk); #2;
      wr_en = 0;
   endtask

   task automatic setin(logic [N-1:0] p, logic [7:0] c);
      @(posedge clk); #2; pend = p; cur_prio = c;
   endtask

   task automatic rd(logic [1:0] s, int idx, logic sec);
      @(posedge clk); #2; rd_sel = s; rd_idx = idx[2:0]; rd_secure = sec;
   endtask

   task automatic settle();
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;

      // R4 / R3: 240 vs running 248
      wr(2'd1, 3, 8'd1, 1'b1);
      wr(2'd0, 3, 8'd240, 1'b0);
      wr(2'd0, 5, 8'd248, 1'b0);
      setin(8'b0000_1000, 8'd248); settle();
      check("R4 boost off 240 preempts 248", a_pre, 1);
      check("R2 b2 boost off preempt", b_pre, 1);
      wr(2'd2, 0, 8'd1, 1'b1); settle();
      check("R4 boost on 240 no preempt", a_pre, 0);
      check("R4 boost on 240 tail_chain", a_tc, 1);
      check("R3 b2 boosted 224 preempts 248", b_pre, 1);
      rd(2'd0, 3, 1'b0); @(negedge clk);
      check("R7 ns readback programmed", a_rd, 240);
      check("R1 b2 readback masked", b_rd, 8'hC0);

      // R8 security of control bits
      wr(2'd2, 0, 8'd0, 1'b0);
      rd(2'd2, 0, 1'b1); @(negedge clk);
      check("R8 ns boost write ignored", a_rd, 1);
      rd(2'd2, 0, 1'b0); @(negedge clk);
      check("R8 ns boost read zero", a_rd, 0);
      wr(2'd1, 3, 8'd0, 1'b0);
      rd(2'd1, 3, 1'b1); @(negedge clk);
      check("R8 ns target write ignored", a_rd, 1);

      // R2 / R3 two-bit mapping
      wr(2'd0, 1, 8'h40, 1'b1);
      setin(8'b0000_0010, 8'h40); settle();
      check("R5 equal priority waits", b_pre, 0);
      check("R5 equal priority tail", b_tc, 1);
      setin(8'b0000_0010, 8'h41); settle();
      check("R2 secure 64 preempts 65", b_pre, 1);
      wr(2'd1, 1, 8'd1, 1'b1);
      setin(8'b0000_0010, 8'hA0); settle();
      check("R3 ns 64 boosted to 160 equal", b_pre, 0);
      setin(8'b0000_0010, 8'hA1); settle();
      check("R3 ns 64 boosted to 160 preempts 161", b_pre, 1);
      wr(2'd2, 0, 8'd0, 1'b1);
      setin(8'b0000_0010, 8'h41); settle();
      check("R2 ns matches secure when boost off", b_pre, 1);

      // R9 tie and boost-driven winner
      wr(2'd0, 6, 8'h40, 1'b1);
      setin(8'b0100_0010, 8'hFF); settle();
      check("R9 tie lowest index", a_id, 1);
      wr(2'd2, 0, 8'd1, 1'b1); settle();
      check("R9 secure wins under boost", a_id, 6);
      check("R9 b2 secure wins under boost", b_id, 6);

      // R6 split
      wr(2'd2, 0, 8'd0, 1'b1);
      wr(2'd0, 2, 8'h48, 1'b1);
      setin(8'b0000_0100, 8'h48); settle();
      check("R6 split 0 equal waits", a_pre, 0);
      wr(2'd3, 0, 8'd4, 1'b0); settle();
      check("R6 split 4 subpriority ignored", a_pre, 1);

      // R1 / R10
      wr(2'd0, 7, 8'hFF, 1'b0);
      rd(2'd0, 7, 1'b0); @(negedge clk);
      check("R1 5-bit low bits zero", a_rd, 8'hF8);
      check("R1 2-bit low bits zero", b_rd, 8'hC0);
      setin('0, 8'h00); settle();
      check("R10 nothing pending", a_v, 0);
      check("R10 nothing pending id", a_id, 0);

      // random phase, compared every cycle
      for (int k = 0; k < 600; k++) begin
         @(posedge clk); #2;
         pend      = N'($urandom);
         cur_prio  = 8'($urandom);
         wr_en     = ($urandom % 3) == 0;
         wr_sel    = 2'($urandom);
         wr_idx    = 3'($urandom);
         wr_data   = 8'($urandom);
         wr_secure = 1'($urandom);
         rd_sel    = 2'($urandom);
         rd_idx    = 3'($urandom);
         rd_secure = 1'($urandom);
      end
      @(posedge clk); #2 wr_en = 0;
      settle();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule